// File: doc/BRIEF.md
# CAN Error Frame Sequencer

This block runs the error frame of a CAN-style bus node, one bit per sample strobe. Another part of the controller reports a detected error. The sequencer then drives the error flag onto the transmit line and rides out any flags that other nodes lay on top of it. It sends the recessive delimiter and times the intermission. If the node is error-passive, it also times the suspend period before the node may transmit again. A dominant level on the last delimiter bit is passed on as an overload-frame request.

The flag takes one of two shapes, chosen by the node's error-passive status at the moment the flag starts. An error-active node drives six dominant bits. An error-passive node drives recessive. Its flag ends only once six equal bus levels have been sampled in a row. CRC errors are deferred, so their flag starts only after the ACK delimiter. Error counting, stuffing, CRC and the content of the overload frame are left to neighbouring logic.

Top module: `can_errframe_seq`

## Requirements
- R1: After reset and whenever idle, `tx_level` is recessive (1), `busy` and `overload_req` are 0, and `tx_permit` is 1 after reset.
- R2: An `err_pulse` sampled with `bit_strobe` while idle, without `err_is_crc`, starts the flag on the next bit. For an error-active node `tx_level` is 0 for exactly 6 bit times, and `busy` goes to 1.
- R3: With `err_is_crc` set, the sequencer waits with `tx_level` recessive. The flag starts on the bit after the strobe where `ack_delim_done` is 1.
- R4: For an error-passive node, `tx_level` stays 1 through the whole frame. The flag ends once 6 consecutive equal `rx_level` samples have been taken, and any change of level restarts that count at 1.
- R5: After the flag, `tx_level` is 1. Dominant samples are absorbed until the first recessive sample, which counts as delimiter bit 1 of 8 recessive delimiter bits.
- R6: A dominant sample on delimiter bit 8 raises `overload_req` for the next bit time. The sequencer then returns to idle with `tx_permit` low.
- R7: An error-active node sets `tx_permit` and returns to idle after 3 recessive intermission bits.
- R8: An error-passive node (status sampled at the end of intermission) must also see 8 recessive suspend bits before `tx_permit` rises.
- R9: A dominant sample during intermission or suspend returns the sequencer to idle with `tx_permit` low.
- R10: `err_pulse` is ignored while busy, and no output changes on a clock without `bit_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| rx_level | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| err_pulse | input | 1 | Error detected in the current bit, valid with the strobe |
| err_is_crc | input | 1 | Qualifies err_pulse as a CRC error |
| ack_delim_done | input | 1 | ACK delimiter bit sampled on this strobe |
| node_passive | input | 1 | Node is error-passive |
| tx_level | output | 1 | Transmit level |
| busy | output | 1 | An error frame is in progress |
| overload_req | output | 1 | Start an overload frame on this bit |
| tx_permit | output | 1 | Node may start a transmission |

## Verification
A wrong internal count shows first at `tx_level` for an active flag: the dominant run becomes shorter or longer than six bits. In every other phase it shows as `tx_permit` or `busy` changing one or more bit times away from the expected strobe. A passive flag drives nothing visible, so an error in its run-length logic is caught through this shifted end of frame. The shift appears 11 to 19 bits later. A missed overload hand-off or a missed start-of-frame abort appears on the very next strobe.

// File: rtl/can_errframe_seq.sv
module can_errframe_seq #(
  parameter int FLAG_BITS    = 6,
  parameter int DELIM_BITS   = 8,
  parameter int INTERM_BITS  = 3,
  parameter int SUSPEND_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_strobe,
  input  logic rx_level,
  input  logic err_pulse,
  input  logic err_is_crc,
  input  logic ack_delim_done,
  input  logic node_passive,
  output logic tx_level,
  output logic busy,
  output logic overload_req,
  output logic tx_permit
);

  localparam int M1 = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
  localparam int M2 = (INTERM_BITS > SUSPEND_BITS) ? INTERM_BITS : SUSPEND_BITS;
  localparam int MAXB = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXB + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WACK, S_FACT, S_FPAS, S_WREC, S_DELIM, S_INTM, S_SUSP, S_OVLD
  } st_t;

  st_t state;
  logic [CW-1:0] cnt;
  logic last_rx;
  logic permit_q;
  logic [CW-1:0] run_next;
  st_t flag_kind;

  assign run_next  = (cnt != '0 && rx_level == last_rx) ? cnt + 1'b1 : CW'(1);
  assign flag_kind = node_passive ? S_FPAS : S_FACT;

  assign tx_level     = (state != S_FACT);
  assign busy         = (state != S_IDLE);
  assign overload_req = (state == S_OVLD);
  assign tx_permit    = permit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      last_rx  <= 1'b1;
      permit_q <= 1'b1;
    end else if (bit_strobe) begin
      case (state)
        S_IDLE:
          if (err_pulse) begin
            permit_q <= 1'b0;
            cnt      <= '0;
            state    <= err_is_crc ? S_WACK : flag_kind;
          end
        S_WACK:
          if (ack_delim_done) begin
            cnt   <= '0;
            state <= flag_kind;
          end
        S_FACT:
          if (cnt == CW'(FLAG_BITS - 1)) begin
            cnt   <= '0;
            state <= S_WREC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_FPAS: begin
          last_rx <= rx_level;
          if (run_next == CW'(FLAG_BITS)) begin
            cnt   <= '0;
            state <= S_WREC;
          end else begin
            cnt <= run_next;
          end
        end
        S_WREC:
          if (rx_level) begin
            cnt   <= CW'(1);
            state <= S_DELIM;
          end
        S_DELIM:
          if (cnt == CW'(DELIM_BITS - 1)) begin
            cnt   <= '0;
            state <= rx_level ? S_INTM : S_OVLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_INTM:
          if (!rx_level) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else if (cnt == CW'(INTERM_BITS - 1)) begin
            cnt <= '0;
            if (node_passive) begin
              state <= S_SUSP;
            end else begin
              state    <= S_IDLE;
              permit_q <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_SUSP:
          if (!rx_level) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else if (cnt == CW'(SUSPEND_BITS - 1)) begin
            cnt      <= '0;
            state    <= S_IDLE;
            permit_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_OVLD:
          state <= S_IDLE;
        default:
          state <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_level);

  // R2
  active_flag_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe && !busy && err_pulse && !err_is_crc && !node_passive |=> !tx_level && busy);

  // R4
  passive_never_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FPAS |-> tx_level);

  // R6
  overload_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overload_req && bit_strobe |=> !overload_req && !busy && !tx_permit);

  // R7
  permit_after_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> $past(bit_strobe) && $past(rx_level));

  // R9
  sof_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe && !rx_level && (state == S_INTM || state == S_SUSP) |=> !busy && !tx_permit);

  // R10
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable({tx_level, busy, overload_req, tx_permit}));

endmodule

// File: tb/can_errframe_seq_test.sv
`timescale 1ns/1ps
module can_errframe_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0, rx_level = 1'b1, err_pulse = 1'b0;
  logic err_is_crc = 1'b0, ack_delim_done = 1'b0, node_passive = 1'b0;
  logic tx_level, busy, overload_req, tx_permit;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  can_errframe_seq uut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_level(rx_level),
    .err_pulse(err_pulse), .err_is_crc(err_is_crc), .ack_delim_done(ack_delim_done),
    .node_passive(node_passive), .tx_level(tx_level), .busy(busy),
    .overload_req(overload_req), .tx_permit(tx_permit)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic rxv, input logic e, input logic crc, input logic ack);
    @(negedge clk);
    rx_level = rxv; bit_strobe = 1'b1; err_pulse = e; err_is_crc = crc; ack_delim_done = ack;
    @(negedge clk);
    bit_strobe = 1'b0; err_pulse = 1'b0; err_is_crc = 1'b0; ack_delim_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "tx_level", tx_level, 1'b1);
    check("R1", "busy", busy, 1'b0);
    check("R1", "overload_req", overload_req, 1'b0);
    check("R1", "tx_permit", tx_permit, 1'b1);
  endtask

  task automatic t_active;
    node_passive = 1'b0;
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", "busy at flag", busy, 1'b1);
    check("R2", "flag bit 1", tx_level, 1'b0);
    for (int i = 1; i <= 5; i++) begin
      tick(1'b0, i == 3, i == 3, 1'b0);
      check("R2", "flag bit", tx_level, 1'b0);
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", "flag ends after 6", tx_level, 1'b1);
    for (int i = 0; i < 2; i++) begin
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5", "absorbing tx", tx_level, 1'b1);
      check("R5", "absorbing busy", busy, 1'b1);
    end
    @(negedge clk);
    rx_level = 1'b0;
    repeat (20) @(negedge clk);
    check("R10", "no strobe busy", busy, 1'b1);
    check("R10", "no strobe permit", tx_permit, 1'b0);
    for (int i = 1; i <= 10; i++) begin
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      check("R7", "permit before end", tx_permit, 1'b0);
      check("R5", "busy through delimiter", busy, 1'b1);
    end
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", "permit after intermission", tx_permit, 1'b1);
    check("R7", "idle after intermission", busy, 1'b0);
  endtask

  task automatic t_crc;
    node_passive = 1'b0;
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    check("R3", "waiting busy", busy, 1'b1);
    check("R3", "waiting tx", tx_level, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3", "still waiting", tx_level, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b1);
    check("R3", "flag after ack delim", tx_level, 1'b0);
    for (int i = 1; i <= 5; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", "deferred flag bit 6", tx_level, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", "deferred flag ended", tx_level, 1'b1);
    for (int i = 1; i <= 11; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", "permit after crc frame", tx_permit, 1'b1);
  endtask

  task automatic t_passive;
    node_passive = 1'b1;
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R4", "passive busy", busy, 1'b1);
    check("R4", "passive tx", tx_level, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "tx during foreign dominant", tx_level, 1'b1);
    for (int k = 1; k <= 25; k++) begin
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      if (k == 17) check("R8", "no permit at active point", tx_permit, 1'b0);
      if (k == 24) begin
        check("R4", "restart delays end", tx_permit, 1'b0);
        check("R8", "busy in suspend", busy, 1'b1);
      end
      if (k == 25) begin
        check("R8", "permit after suspend", tx_permit, 1'b1);
        check("R4", "idle after passive frame", busy, 1'b0);
      end
    end
    node_passive = 1'b0;
  endtask

  task automatic t_overload;
    node_passive = 1'b0;
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 1; i <= 6; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 7; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "no request before bit 8", overload_req, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6", "overload request", overload_req, 1'b1);
    check("R6", "busy in hand-off", busy, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "request one bit", overload_req, 1'b0);
    check("R6", "idle after hand-off", busy, 1'b0);
    check("R6", "no permit after overload", tx_permit, 1'b0);
  endtask

  task automatic t_sof;
    node_passive = 1'b0;
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 1; i <= 6; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 9; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", "idle on foreign SOF", busy, 1'b0);
    check("R9", "permit cleared", tx_permit, 1'b0);
    check("R1", "idle tx recessive", tx_level, 1'b1);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", "new error accepted", tx_level, 1'b0);
    for (int i = 1; i <= 6; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 11; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", "permit restored", tx_permit, 1'b1);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_active();
    t_crc();
    t_passive();
    t_overload();
    t_sof();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule